// File: doc/BRIEF.md
# Sixteen-bit Arithmetic, Logic and Shift Unit with Status Flags

This block is the execution unit of a small 16-bit accumulator-style processor. It receives two prepared operands, a 4-bit operation code and the carry flag currently held by the processor. It returns a combinational result and a destination write enable. It supports addition, subtraction, three bitwise functions, and four one-position shifts. Two of the shifts fill the vacated bit with zero, and two fill it with the incoming carry.

The block also holds the status flags: zero, carry, overflow, positive and negative. The flags are captured on the rising clock edge when the surrounding control asserts a flag-update strobe and the operation is one that affects flags. Compare and test are subtract and AND variants that refresh the flags but keep the write enable low. Because of them, a program can inspect a register without destroying its contents.

Top module: `alu_core`

## Requirements
- R1: Operation code 0000 (add) gives result = opA + opB modulo 2^16; its carry is the carry out of bit 15, and its overflow is set when both operands share a sign that differs from the result sign.
- R2: Code 0001 (subtract) gives opA - opB; its carry is 1 when no borrow occurs (opA >= opB unsigned), and its overflow is set when the operand signs differ and the result sign differs from opA.
- R3: Codes 0100, 0101 and 0110 give opA AND, OR and XOR opB respectively, selected by the two low code bits (00 AND, 01 OR, 10 XOR).
- R4: Codes 1000 (left) and 1001 (right) shift opA one position and place 0 in the vacated bit (bit 0 for left, bit 15 for right).
- R5: Codes 1010 (left) and 1011 (right) shift opA one position and place carryIn in the vacated bit.
- R6: For every shift, the carry written to the flags is the bit shifted out: bit 15 of opA for a left shift, bit 0 for a right shift.
- R7: Code 0010 (compare, opA - opB) and code 0111 (test, opA AND opB) hold wrEn low and update all five flags exactly as subtract and AND would.
- R8: OR and XOR assert wrEn but leave all five flags unchanged.
- R9: Flag meaning: Z = result is zero, N = result bit 15, P = result nonzero with bit 15 clear. Overflow is cleared by AND, test and all shifts, and carry is cleared by AND and test.
- R10: Flags change only on a rising clock edge with flagUpd high; a synchronous high rst clears all five flags whatever flagUpd is.
- R11: Reserved codes (0011 and 11xx) give result 0 and wrEn low, and leave the flags unchanged.
- R12: wrEn is high for add, subtract, AND, OR, XOR and all four shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| opA | input | 16 | First operand, also the shift source |
| opB | input | 16 | Second operand |
| opSel | input | 4 | Operation code |
| carryIn | input | 1 | Current carry flag used as shift fill |
| flagUpd | input | 1 | Flag-capture strobe |
| result | output | 16 | Combinational result |
| wrEn | output | 1 | Destination register write enable |
| flagZ | output | 1 | Registered zero flag |
| flagC | output | 1 | Registered carry flag |
| flagO | output | 1 | Registered overflow flag |
| flagP | output | 1 | Registered positive flag |
| flagN | output | 1 | Registered negative flag |

## Verification
The adder is tried with small sums, a signed overflow at 0x7FFF+1 and a full wrap at 0xFFFF+1. These separate the carry from the overflow and show zero arising from a carry. Subtraction is tried with equal operands, a borrow and a negative-to-positive overflow, which tell the no-borrow carry apart from the sign flags. Shifts run on all-ones and single-bit patterns with the carry in set and clear. This exposes the fill source and the bit shifted out independently, because the two differ in those cases. The remaining checks are flag-preserving forms (OR, XOR, reserved codes, strobe low) placed after a known flag state, then compare and test, which must change flags while keeping wrEn low.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [3:0] OP_ADD  = 4'b0000;
  localparam logic [3:0] OP_SUB  = 4'b0001;
  localparam logic [3:0] OP_CMP  = 4'b0010;
  localparam logic [3:0] OP_AND  = 4'b0100;
  localparam logic [3:0] OP_OR   = 4'b0101;
  localparam logic [3:0] OP_XOR  = 4'b0110;
  localparam logic [3:0] OP_TEST = 4'b0111;
  localparam logic [3:0] OP_ASL  = 4'b1000;
  localparam logic [3:0] OP_ASR  = 4'b1001;
  localparam logic [3:0] OP_SHL  = 4'b1010;
  localparam logic [3:0] OP_SHR  = 4'b1011;

  typedef enum logic [1:0] {
    UNIT_ADD   = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2,
    UNIT_NONE  = 2'd3
  } unit_e;

  typedef struct packed {
    unit_e      unitSel;
    logic       subtract;
    logic [1:0] logicFn;
    logic       shiftRight;
    logic       fillCarry;
    logic       wrEn;
    logic       flagEn;
  } ctrl_s;

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] din,
  input  logic              shiftRight,
  input  logic              fillCarry,
  input  logic              carryIn,
  output logic [DATA_W-1:0] dout,
  output logic              cout
);
  localparam int MSB = DATA_W - 1;

  logic bubble;
  logic [DATA_W-1:0] leftVal;
  logic [DATA_W-1:0] rightVal;

  assign bubble = fillCarry ? carryIn : 1'b0;

  // fixed one-position wiring in each direction
  genvar i;
  generate
    for (i = 1; i < DATA_W; i++) begin : g_wire
      assign leftVal[i]    = din[i-1];
      assign rightVal[i-1] = din[i];
    end
  endgenerate
  assign leftVal[0]    = bubble;
  assign rightVal[MSB] = bubble;

  always_comb begin
    if (shiftRight) begin
      dout = rightVal;
      cout = din[0];
    end else begin
      dout = leftVal;
      cout = din[MSB];
    end
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opSel,
  output ctrl_s      strobes
);
  always_comb begin
    strobes.unitSel    = UNIT_NONE;
    strobes.subtract   = 1'b0;
    strobes.logicFn    = 2'b00;
    strobes.shiftRight = 1'b0;
    strobes.fillCarry  = 1'b0;
    strobes.wrEn       = 1'b0;
    strobes.flagEn     = 1'b0;
    case (opSel)
      OP_ADD, OP_SUB, OP_CMP: begin
        strobes.unitSel  = UNIT_ADD;
        strobes.subtract = (opSel != OP_ADD);
        strobes.wrEn     = (opSel != OP_CMP);
        strobes.flagEn   = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_TEST: begin
        strobes.unitSel = UNIT_LOGIC;
        strobes.logicFn = (opSel == OP_TEST) ? 2'b00 : opSel[1:0];
        strobes.wrEn    = (opSel != OP_TEST);
        strobes.flagEn  = (opSel == OP_AND) || (opSel == OP_TEST);
      end
      OP_ASL, OP_ASR, OP_SHL, OP_SHR: begin
        strobes.unitSel    = UNIT_SHIFT;
        strobes.shiftRight = opSel[0];
        strobes.fillCarry  = opSel[1];
        strobes.wrEn       = 1'b1;
        strobes.flagEn     = 1'b1;
      end
      default: ;
    endcase
  end

  // R7: compare and test never write the destination but do touch flags
  a_r7_no_write: assert property (@(posedge clk) disable iff (rst)
    ((opSel == OP_CMP) || (opSel == OP_TEST)) |-> (!strobes.wrEn && strobes.flagEn));

  // R11: reserved codes neither write nor update flags
  a_r11_reserved_idle: assert property (@(posedge clk) disable iff (rst)
    (strobes.unitSel == UNIT_NONE) |-> (!strobes.wrEn && !strobes.flagEn));
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_s             strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              flagUpd,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        flags
);
  localparam int MSB = DATA_W - 1;
  localparam int FZ = 4, FC = 3, FO = 2, FP = 1, FN = 0;

  // adder / subtractor
  logic [DATA_W-1:0] addB;
  logic [DATA_W-1:0] sum;
  logic              addCarry;
  logic              addOvf;

  assign addB = strobes.subtract ? ~opB : opB;
  assign {addCarry, sum} = {1'b0, opA} + {1'b0, addB} + {{DATA_W{1'b0}}, strobes.subtract};
  assign addOvf = (opA[MSB] == addB[MSB]) && (sum[MSB] != opA[MSB]);

  // boolean gate arrays
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    case (strobes.logicFn)
      2'b01:   logicRes = opA | opB;
      2'b10:   logicRes = opA ^ opB;
      default: logicRes = opA & opB;
    endcase
  end

  // shifter
  logic [DATA_W-1:0] shiftRes;
  logic              shiftCarry;

  alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .din        (opA),
    .shiftRight (strobes.shiftRight),
    .fillCarry  (strobes.fillCarry),
    .carryIn    (carryIn),
    .dout       (shiftRes),
    .cout       (shiftCarry)
  );

  // result and carry-source selection
  logic carryNext;
  logic ovfNext;
  always_comb begin
    case (strobes.unitSel)
      UNIT_ADD: begin
        result    = sum;
        carryNext = addCarry;
        ovfNext   = addOvf;
      end
      UNIT_LOGIC: begin
        result    = logicRes;
        carryNext = 1'b0;
        ovfNext   = 1'b0;
      end
      UNIT_SHIFT: begin
        result    = shiftRes;
        carryNext = shiftCarry;
        ovfNext   = 1'b0;
      end
      default: begin
        result    = '0;
        carryNext = 1'b0;
        ovfNext   = 1'b0;
      end
    endcase
  end

  logic [4:0] flagNext;
  logic       isZero;
  assign isZero = (result == '0);
  always_comb begin
    flagNext[FZ] = isZero;
    flagNext[FC] = carryNext;
    flagNext[FO] = ovfNext;
    flagNext[FP] = !isZero && !result[MSB];
    flagNext[FN] = result[MSB];
  end

  always_ff @(posedge clk) begin
    if (rst)
      flags <= '0;
    else if (flagUpd && strobes.flagEn)
      flags <= flagNext;
  end

  // R10: reset clears every flag on the following cycle
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (flags == 5'b00000));

  // R10: without the strobe the flags do not move
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !flagUpd |=> $stable(flags));

  // R9: zero, positive and negative are mutually exclusive
  a_r9_sign_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flags[FZ], flags[FP], flags[FN]}));

  // R9: logic and shift operations leave overflow clear
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (flagUpd && strobes.flagEn && (strobes.unitSel != UNIT_ADD)) |=> !flags[FO]);

  // R4: zero-fill left shift puts 0 in bit 0
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (rst)
    ((strobes.unitSel == UNIT_SHIFT) && !strobes.shiftRight && !strobes.fillCarry)
      |-> (result[0] == 1'b0));
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        opSel,
  input  logic              carryIn,
  input  logic              flagUpd,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagO,
  output logic              flagP,
  output logic              flagN
);
  ctrl_s      strobes;
  logic [4:0] flags;

  alu_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .flagUpd (flagUpd),
    .result  (result),
    .flags   (flags)
  );

  assign wrEn = strobes.wrEn;
  assign {flagZ, flagC, flagO, flagP, flagN} = flags;
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] opA, opB;
  logic [3:0]  opSel;
  logic        carryIn, flagUpd;
  logic [15:0] result;
  logic        wrEn, flagZ, flagC, flagO, flagP, flagN;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  alu_core u0 (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opSel(opSel),
    .carryIn(carryIn), .flagUpd(flagUpd), .result(result), .wrEn(wrEn),
    .flagZ(flagZ), .flagC(flagC), .flagO(flagO), .flagP(flagP), .flagN(flagN)
  );

  // row: op, a, b, carryIn, expected result, expected wrEn, expected {Z,C,O,P,N}
  localparam int NV = 18;
  localparam logic [58:0] VEC [NV] = '{
    {4'h0, 16'h0001, 16'h0001, 1'b0, 16'h0002, 1'b1, 5'b00010},  // R1
    {4'h0, 16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b1, 5'b00101},  // R1 overflow
    {4'h0, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 5'b11000},  // R1 wrap
    {4'h1, 16'h0005, 16'h0005, 1'b0, 16'h0000, 1'b1, 5'b11000},  // R2 equal
    {4'h1, 16'h0000, 16'h0001, 1'b0, 16'hFFFF, 1'b1, 5'b00001},  // R2 borrow
    {4'h1, 16'h8000, 16'h0001, 1'b0, 16'h7FFF, 1'b1, 5'b01110},  // R2 overflow
    {4'h2, 16'h0005, 16'h000A, 1'b0, 16'hFFFB, 1'b0, 5'b00001},  // R7 compare
    {4'h4, 16'hFFFF, 16'h0055, 1'b0, 16'h0055, 1'b1, 5'b00010},  // R3 AND
    {4'h5, 16'h0055, 16'h00AA, 1'b0, 16'h00FF, 1'b1, 5'b00010},  // R3 R8 OR
    {4'h6, 16'h00FF, 16'h00CC, 1'b0, 16'h0033, 1'b1, 5'b00010},  // R3 R8 XOR
    {4'h7, 16'h0033, 16'h0004, 1'b0, 16'h0000, 1'b0, 5'b10000},  // R7 test
    {4'h8, 16'hFFFF, 16'h0000, 1'b0, 16'hFFFE, 1'b1, 5'b01001},  // R4 R6
    {4'hA, 16'hFFFE, 16'h0000, 1'b1, 16'hFFFD, 1'b1, 5'b01001},  // R5 R6
    {4'h9, 16'hFFFD, 16'h0000, 1'b1, 16'h7FFE, 1'b1, 5'b01010},  // R4 R6
    {4'hB, 16'h7FFE, 16'h0000, 1'b1, 16'hBFFF, 1'b1, 5'b00001},  // R5 R6
    {4'hB, 16'h0001, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'b11000},  // R5 R6
    {4'hA, 16'h8000, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'b11000},  // R5 R6
    {4'hC, 16'h1234, 16'h5678, 1'b1, 16'h0000, 1'b0, 5'b11000}   // R11
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2, 4'h7: return "R7";
      4'h4: return "R3";
      4'h5, 4'h6: return "R8";
      4'h8, 4'h9: return "R4";
      4'hA, 4'hB: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] flagVec();
    return {11'd0, flagZ, flagC, flagO, flagP, flagN};
  endfunction

  // drive after a negedge, check comb outputs, then flags at the next negedge
  task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic cin, input logic upd, input string req,
                       input logic [15:0] expRes, input logic expWr, input logic [4:0] expF);
    opSel = op; opA = a; opB = b; carryIn = cin; flagUpd = upd;
    #1;
    check(req, "result", result, expRes);
    check(req, "wrEn", {15'd0, wrEn}, {15'd0, expWr});
    @(negedge clk);
    check(req, "flags", flagVec(), {11'd0, expF});
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; opA = '0; opB = '0; opSel = 4'h0; carryIn = 1'b0; flagUpd = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "reset flags", flagVec(), 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [58:0] v;
      v = VEC[i];
      apply(v[58:55], v[54:39], v[38:23], v[22], 1'b1, reqOf(v[58:55]),
            v[21:6], v[5], v[4:0]);
    end

    // R11: reserved 0011 holds flags after known state
    apply(4'h0, 16'h0001, 16'h0001, 1'b0, 1'b1, "R1", 16'h0002, 1'b1, 5'b00010);
    apply(4'h3, 16'hFFFF, 16'h0001, 1'b0, 1'b1, "R11", 16'h0000, 1'b0, 5'b00010);
    // R12: wrEn high on subtract/shift rows already; R10: strobe low holds flags
    apply(4'h0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, "R10", 16'h0000, 1'b1, 5'b00010);
    // R9: overflow set then cleared by AND
    apply(4'h0, 16'h7FFF, 16'h0001, 1'b0, 1'b1, "R9", 16'h8000, 1'b1, 5'b00101);
    apply(4'h4, 16'h8000, 16'hFFFF, 1'b0, 1'b1, "R9", 16'h8000, 1'b1, 5'b00001);
    // R9: carry set then cleared by AND
    apply(4'h0, 16'hFFFF, 16'h0001, 1'b0, 1'b1, "R9", 16'h0000, 1'b1, 5'b11000);
    apply(4'h4, 16'h00FF, 16'h0F0F, 1'b0, 1'b1, "R9", 16'h000F, 1'b1, 5'b00010);
    // R12: XOR writes, R8 flags untouched after a negative result
    apply(4'h1, 16'h0000, 16'h0001, 1'b0, 1'b1, "R2", 16'hFFFF, 1'b1, 5'b00001);
    apply(4'h6, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R12", 16'h0000, 1'b1, 5'b00001);
    // R10: reset mid-run with strobe low still clears
    flagUpd = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R10", "reset mid-run", flagVec(), 16'h0000);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule